// File: doc/BRIEF.md
# Serial Flash Identification Reader

This block fetches the identification of a serial NOR flash device through an SPI byte shifter when it sees a start pulse. It selects the device and sends the read-identification opcode. It then reads manufacturer bytes one at a time. Each continuation byte moves a bank counter up by one. The first byte that is not a continuation byte is taken as the manufacturer code, and it must have odd parity. When the code is accepted, the block reads two device bytes, releases the select line and publishes the bank, the manufacturer code and both device bytes.

The block talks to a byte shifter that is external to it. For each byte, `xfer_req_o` is asserted for one cycle together with `xfer_tx_o`. The shifter answers with `xfer_done_i` and the received byte `xfer_rx_i` after any number of cycles. The select line `cs_o` stays asserted from the first byte to the last byte, so the whole exchange is one transaction. `done_o` marks the end of every attempt. `err_o` tells a failed attempt apart from a successful one, and a failed attempt leaves the published identification unchanged. A bank limit stops the scan, so a bus stuck at the continuation value cannot keep the block busy forever.

Top module: `flash_id_reader`

## Requirements
- R1: After reset, `bank_o`, `manuf_o`, `dev0_o`, `dev1_o`, `done_o`, `err_o`, `cs_o` and `xfer_req_o` are all 0.
- R2: The first byte transfer of an attempt sends `OPCODE` (default 0x9F). Every later transfer sends 0x00. Each request lasts exactly one cycle.
- R3: `cs_o` is 1 during every transfer of an attempt. It falls in the same cycle that `done_o` rises.
- R4: The bank counter starts at 1. Each received byte equal to `CONT_CODE` (default 0x7F) raises it by one, and another manufacturer byte is then read. On success, `bank_o` equals 1 plus the number of continuation bytes.
- R5: The first received byte that is not a continuation byte is accepted as the manufacturer code when the XOR of its 8 bits is 1.
- R6: A manufacturer byte with even parity ends the attempt with `err_o`=1. No device bytes are read, so the attempt has n+2 transfers, where n is the number of continuation bytes.
- R7: On success, exactly two more bytes are read, into `dev0_o` and then `dev1_o`. The attempt has n+4 transfers, and `err_o` is 0.
- R8: `bank_o`, `manuf_o`, `dev0_o` and `dev1_o` change only in a cycle where `done_o` is 1 with `err_o`=0. An error leaves them unchanged.
- R9: A continuation byte that arrives while the bank is already `MAX_BANK` (default 16) ends the attempt with `err_o`=1. With the defaults, this is the 16th continuation byte, for 17 transfers in total.
- R10: `start_i` has no effect while an attempt is in progress.
- R11: `done_o` is a single-cycle pulse. `err_o` holds the result of the last attempt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts an identification attempt when idle |
| xfer_req_o | output | 1 | One-cycle request for one byte transfer |
| xfer_tx_o | output | 8 | Byte to send in the requested transfer |
| xfer_done_i | input | 1 | The shifter has finished the byte |
| xfer_rx_i | input | 8 | Byte received, valid with xfer_done_i |
| cs_o | output | 1 | Device select, 1 = selected |
| bank_o | output | BANK_W | Published bank number |
| manuf_o | output | 8 | Published manufacturer code |
| dev0_o | output | 8 | Published device byte 0 |
| dev1_o | output | 8 | Published device byte 1 |
| done_o | output | 1 | Attempt finished (pulse) |
| err_o | output | 1 | Last attempt failed |

## Verification
With no continuation bytes, every manufacturer value from 0x00 to 0xFF except 0x7F is offered. This divides all byte values into accepted codes and parity rejects, and it confirms that a reject changes none of the held outputs. The number of continuation bytes is then swept from 0 to 17. This shows that the bank follows the count up to the limit and that the 16th continuation byte aborts. The shifter latency changes from one run to the next. In some runs, a second start pulse arrives while an attempt is in progress, which shows that the transfer count does not depend on the timing of the handshake or on stray starts.

// File: rtl/idr_pkg.sv
package idr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEND_OP,
    ST_WAIT_OP,
    ST_SEND_MF,
    ST_WAIT_MF,
    ST_SEND_DV,
    ST_WAIT_DV
  } idr_state_e;
endpackage

// File: rtl/idr_parity.sv
module idr_parity #(
  parameter int W = 8
) (
  input  logic [W-1:0] data_i,
  output logic         odd_o
);
  localparam int STAGES = $clog2(W);

  logic [W-1:0] fold [0:STAGES];
  assign fold[0] = data_i;

  // halve the span each stage: shifts W/2, W/4, ... 1
  for (genvar s = 0; s < STAGES; s++) begin : g_fold
    assign fold[s+1] = fold[s] ^ (fold[s] >> (W >> (s + 1)));
  end

  assign odd_o = fold[STAGES][0];
endmodule

// File: rtl/idr_bank_ctr.sv
module idr_bank_ctr #(
  parameter int MAX_BANK = 16,
  parameter int BANK_W   = $clog2(MAX_BANK + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              inc_i,
  output logic [BANK_W-1:0] bank_o,
  output logic              at_max_o
);
  localparam logic [BANK_W-1:0] FIRST = BANK_W'(1);
  localparam logic [BANK_W-1:0] LAST  = BANK_W'(MAX_BANK);

  logic [BANK_W-1:0] bank_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    bank_q <= FIRST;
    else if (clr_i)                 bank_q <= FIRST;
    else if (inc_i && bank_q != LAST) bank_q <= bank_q + FIRST;
  end

  assign bank_o   = bank_q;
  assign at_max_o = (bank_q == LAST);
endmodule

// File: rtl/idr_seq.sv
module idr_seq
  import idr_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic xfer_done_i,
  input  logic rx_is_cont_i,
  input  logic rx_odd_i,
  input  logic at_max_i,
  output logic req_o,
  output logic send_op_o,
  output logic accept_o,
  output logic bank_inc_o,
  output logic latch_mf_o,
  output logic latch_d0_o,
  output logic commit_o,
  output logic fail_o
);
  idr_state_e st_q, st_d;
  logic       dev_idx_q, dev_idx_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      dev_idx_q <= 1'b0;
    end else begin
      st_q      <= st_d;
      dev_idx_q <= dev_idx_d;
    end
  end

  always_comb begin
    st_d       = st_q;
    dev_idx_d  = dev_idx_q;
    accept_o   = 1'b0;
    bank_inc_o = 1'b0;
    latch_mf_o = 1'b0;
    latch_d0_o = 1'b0;
    commit_o   = 1'b0;
    fail_o     = 1'b0;
    unique case (st_q)
      ST_IDLE: if (start_i) begin
        accept_o = 1'b1;
        st_d     = ST_SEND_OP;
      end
      ST_SEND_OP: st_d = ST_WAIT_OP;
      ST_WAIT_OP: if (xfer_done_i) st_d = ST_SEND_MF;
      ST_SEND_MF: st_d = ST_WAIT_MF;
      ST_WAIT_MF: if (xfer_done_i) begin
        if (rx_is_cont_i) begin
          if (at_max_i) begin
            fail_o = 1'b1;
            st_d   = ST_IDLE;
          end else begin
            bank_inc_o = 1'b1;
            st_d       = ST_SEND_MF;
          end
        end else if (!rx_odd_i) begin
          fail_o = 1'b1;
          st_d   = ST_IDLE;
        end else begin
          latch_mf_o = 1'b1;
          dev_idx_d  = 1'b0;
          st_d       = ST_SEND_DV;
        end
      end
      ST_SEND_DV: st_d = ST_WAIT_DV;
      ST_WAIT_DV: if (xfer_done_i) begin
        if (!dev_idx_q) begin
          latch_d0_o = 1'b1;
          dev_idx_d  = 1'b1;
          st_d       = ST_SEND_DV;
        end else begin
          commit_o = 1'b1;
          st_d     = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  assign req_o     = (st_q == ST_SEND_OP) || (st_q == ST_SEND_MF) || (st_q == ST_SEND_DV);
  assign send_op_o = (st_q == ST_SEND_OP);
endmodule

// File: rtl/flash_id_reader.sv
module flash_id_reader #(
  parameter int          MAX_BANK  = 16,
  parameter logic [7:0]  OPCODE    = 8'h9F,
  parameter logic [7:0]  CONT_CODE = 8'h7F,
  parameter int          BANK_W    = $clog2(MAX_BANK + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic              xfer_req_o,
  output logic [7:0]        xfer_tx_o,
  input  logic              xfer_done_i,
  input  logic [7:0]        xfer_rx_i,
  output logic              cs_o,
  output logic [BANK_W-1:0] bank_o,
  output logic [7:0]        manuf_o,
  output logic [7:0]        dev0_o,
  output logic [7:0]        dev1_o,
  output logic              done_o,
  output logic              err_o
);
  logic              rx_odd, rx_is_cont, at_max;
  logic              send_op, accept, bank_inc, latch_mf, latch_d0, commit, fail;
  logic [BANK_W-1:0] bank_cur;
  logic [7:0]        mf_work_q, d0_work_q;
  logic              cs_q, done_q, err_q;
  logic [BANK_W-1:0] bank_q;
  logic [7:0]        manuf_q, dev0_q, dev1_q;

  assign rx_is_cont = (xfer_rx_i == CONT_CODE);

  idr_parity #(.W(8)) u_parity (
    .data_i (xfer_rx_i),
    .odd_o  (rx_odd)
  );

  idr_bank_ctr #(.MAX_BANK(MAX_BANK), .BANK_W(BANK_W)) u_bank (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (accept),
    .inc_i    (bank_inc),
    .bank_o   (bank_cur),
    .at_max_o (at_max)
  );

  idr_seq u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .xfer_done_i  (xfer_done_i),
    .rx_is_cont_i (rx_is_cont),
    .rx_odd_i     (rx_odd),
    .at_max_i     (at_max),
    .req_o        (xfer_req_o),
    .send_op_o    (send_op),
    .accept_o     (accept),
    .bank_inc_o   (bank_inc),
    .latch_mf_o   (latch_mf),
    .latch_d0_o   (latch_d0),
    .commit_o     (commit),
    .fail_o       (fail)
  );

  assign xfer_tx_o = send_op ? OPCODE : 8'h00;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mf_work_q <= '0;
      d0_work_q <= '0;
    end else begin
      if (latch_mf) mf_work_q <= xfer_rx_i;
      if (latch_d0) d0_work_q <= xfer_rx_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_q    <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      bank_q  <= '0;
      manuf_q <= '0;
      dev0_q  <= '0;
      dev1_q  <= '0;
    end else begin
      done_q <= commit | fail;
      if (accept)             cs_q <= 1'b1;
      else if (commit | fail) cs_q <= 1'b0;
      if (commit | fail)      err_q <= fail;
      if (commit) begin
        bank_q  <= bank_cur;
        manuf_q <= mf_work_q;
        dev0_q  <= d0_work_q;
        dev1_q  <= xfer_rx_i;
      end
    end
  end

  assign cs_o    = cs_q;
  assign done_o  = done_q;
  assign err_o   = err_q;
  assign bank_o  = bank_q;
  assign manuf_o = manuf_q;
  assign dev0_o  = dev0_q;
  assign dev1_o  = dev1_q;
endmodule

// File: rtl/idr_checker.sv
module idr_checker #(
  parameter int MAX_BANK = 16,
  parameter int BANK_W   = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              xfer_req_o,
  input logic              cs_o,
  input logic              done_o,
  input logic              err_o,
  input logic [BANK_W-1:0] bank_o,
  input logic [7:0]        manuf_o,
  input logic [7:0]        dev0_o,
  input logic [7:0]        dev1_o
);
  assert_req_single_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_req_o |=> !xfer_req_o);

  assert_req_selected_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_req_o |-> cs_o);

  assert_cs_release_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_o) |-> done_o);

  assert_bank_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !err_o) |-> (bank_o >= BANK_W'(1) && bank_o <= BANK_W'(MAX_BANK)));

  assert_hold_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && !err_o) |-> ($stable(bank_o) && $stable(manuf_o) && $stable(dev0_o) && $stable(dev1_o)));

  assert_done_pulse_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_idle_no_req_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !xfer_req_o);
endmodule

bind flash_id_reader idr_checker #(.MAX_BANK(MAX_BANK), .BANK_W(BANK_W)) u_idr_checker (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .xfer_req_o (xfer_req_o),
  .cs_o       (cs_o),
  .done_o     (done_o),
  .err_o      (err_o),
  .bank_o     (bank_o),
  .manuf_o    (manuf_o),
  .dev0_o     (dev0_o),
  .dev1_o     (dev1_o)
);

// File: tb/flash_id_reader_bench.sv
module flash_id_reader_bench;
  localparam int BW = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          req;
  logic [7:0]    tx;
  logic          xdone = 1'b0;
  logic [7:0]    xrx = 8'h00;
  logic          cs, done, err;
  logic [BW-1:0] bank;
  logic [7:0]    manuf, dev0, dev1;

  always #5 clk = ~clk;

  flash_id_reader u_flash_id_reader (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .xfer_req_o(req), .xfer_tx_o(tx), .xfer_done_i(xdone), .xfer_rx_i(xrx),
    .cs_o(cs), .bank_o(bank), .manuf_o(manuf), .dev0_o(dev0), .dev1_o(dev1),
    .done_o(done), .err_o(err)
  );

  int         n_chk = 0;
  int         n_fail = 0;
  bit         finished = 0;
  logic [7:0] rsp [0:31];
  int         xcnt = 0;
  int         bad_tx = 0;
  int         bad_cs = 0;
  int         lat = 1;
  logic [BW-1:0] e_bank = '0;
  logic [7:0] e_mf = 8'h00, e_d0 = 8'h00, e_d1 = 8'h00;

  task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  // byte shifter model
  initial begin
    forever begin
      @(negedge clk);
      while (req) begin
        if (xcnt == 0 && tx != 8'h9F) bad_tx++;
        if (xcnt != 0 && tx != 8'h00) bad_tx++;
        if (!cs) bad_cs++;
        repeat (lat) @(negedge clk);
        xrx   = rsp[xcnt < 32 ? xcnt : 31];
        xdone = 1'b1;
        xcnt++;
        @(negedge clk);
        xdone = 1'b0;
      end
    end
  end

  task automatic run_id(input int n, input logic [7:0] mf, input logic [7:0] d0,
                        input logic [7:0] d1, input int l, input bit extra_start);
    int  exp_x;
    bit  exp_err;
    int  cyc;
    for (int i = 0; i < 32; i++) rsp[i] = 8'hEE;
    rsp[0] = 8'hFF;
    for (int i = 1; i <= n && i < 32; i++) rsp[i] = 8'h7F;
    if (n < 16) begin
      rsp[n+1] = mf;
      rsp[n+2] = d0;
      rsp[n+3] = d1;
    end
    if (n >= 16) begin
      exp_err = 1;
      exp_x   = 17;
    end else if (^mf == 1'b0) begin
      exp_err = 1;
      exp_x   = n + 2;
    end else begin
      exp_err = 0;
      exp_x   = n + 4;
    end
    lat = l; xcnt = 0; bad_tx = 0; bad_cs = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    cyc = 0;
    while (!done && cyc < 2000) begin
      if (extra_start && cyc == 4) start = 1'b1;
      else start = 1'b0;
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    chk(done == 1'b1, "R11", "done seen", int'(done), 1);
    chk(cs == 1'b0, "R3", "cs released with done", int'(cs), 0);
    chk(bad_cs == 0, "R3", "cs during transfer", bad_cs, 0);
    chk(bad_tx == 0, "R2", "tx bytes", bad_tx, 0);
    chk(err == exp_err, n >= 16 ? "R9" : (exp_err ? "R6" : "R5"), "err", int'(err), int'(exp_err));
    chk(xcnt == exp_x, exp_err ? "R6" : "R7", "transfer count", xcnt, exp_x);
    if (!exp_err) begin
      e_bank = BW'(n + 1); e_mf = mf; e_d0 = d0; e_d1 = d1;
    end
    chk(bank == e_bank, exp_err ? "R8" : "R4", "bank", int'(bank), int'(e_bank));
    chk(manuf == e_mf, exp_err ? "R8" : "R5", "manuf", int'(manuf), int'(e_mf));
    chk(dev0 == e_d0 && dev1 == e_d1, exp_err ? "R8" : "R7", "device bytes",
        int'({dev0, dev1}), int'({e_d0, e_d1}));
    @(negedge clk);
    chk(done == 1'b0, "R11", "done one cycle", int'(done), 0);
    chk(err == exp_err, "R11", "err held", int'(err), int'(exp_err));
    repeat (3) @(negedge clk);
    chk(xcnt == exp_x && !req && !cs, "R10", "no activity after end", xcnt, exp_x);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(bank == 0 && manuf == 0 && dev0 == 0 && dev1 == 0, "R1", "id outputs reset",
        int'({manuf, dev0}), 0);
    chk(!done && !err && !cs && !req, "R1", "control reset", int'({done, err, cs, req}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    for (int m = 0; m < 256; m++) begin
      if (m != 8'h7F)
        run_id(0, 8'(m), 8'(m ^ 8'h5A), 8'(m + 3), (m % 3) + 1, (m % 7) == 0);
    end
    for (int n = 0; n <= 17; n++) begin
      run_id(n, 8'h01 + 8'(2 * n) | 8'h80 ^ 8'h80, 8'(n + 8'h40), 8'(8'hC0 - n), (n % 3) + 1, (n % 2) == 1);
      run_id(n, 8'h03, 8'h11, 8'h22, 2, 0);
    end
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #1500000;
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule